// File: doc/BRIEF.md
# Retirement Trace Recorder

This block sits beside the completion stage of a single processor pipeline and keeps a compact history of what that stage did. Each cycle the pipeline may present one event: an instruction retiring normally, a stall, or an exception. The event comes with the instruction address, the virtual address of any load or store, and the value being written back to the register file. A programmable filter decides which events are kept. Kept events become records in a small on-chip circular buffer, and a host empties that buffer through a valid/ready read port.

To save buffer space, a retiring instruction whose address follows the previously recorded one by exactly one instruction size is stored without its address. Only a break in flow carries a full address. Such breaks are a jump, an exception, the first event after capture is switched on, and the first event after the buffer has lost history. Runs of consecutive stalls fold into one record that carries a saturating repeat count. Internally one staging register holds the newest record. It is managed by a three-state machine: `ST_IDLE` (nothing staged), `ST_HOLD` (a retire or exception record staged) and `ST_MERGE` (a stall run being counted). The transitions are named T_LOAD_REC (load a retire or exception into `ST_HOLD`), T_LOAD_STALL (load a stall into `ST_MERGE`), T_MERGE (stay in `ST_MERGE` and count one more stall), T_FLUSH (commit the staged record and go to `ST_IDLE`) and T_STAY (no change). A record from `ST_HOLD` reaches the buffer one clock after it enters staging. A stall record reaches the buffer when its run ends.

Top module: `trace_capture`

## Requirements
- R1: After reset the read port shows no record (`rd_valid` low) and `wrap_flag` is low.
- R2: Record kinds are encoded on `rt_kind`/`rd_kind` as 0 = retire, 1 = stall, 2 = exception. Retire and exception records carry the data address and write-back value unchanged. Stall records carry zero in the address, data-address and value fields.
- R3: A retire record whose address equals the last recorded retire/exception address plus `INSN_BYTES` has `rd_full` = 0 and a zero address field.
- R4: A retire record that breaks the sequence (a jump) has `rd_full` = 1 and the full address. Every exception record has `rd_full` = 1 and the full address.
- R5: The first retire or exception record taken after `cfg_enable` has been low is full, even if its address is sequential.
- R6: `cfg_type_mask` bit 0 enables retire records, bit 1 stall records and bit 2 exception records. Events of a disabled kind leave no record.
- R7: An event is kept only when `cfg_pc_lo` <= address <= `cfg_pc_hi`, with both bounds inclusive.
- R8: Consecutive kept stall cycles form one record whose `rd_repeat` equals the run length, saturating at 255. The run ends on any other valid event or when capture is disabled. Non-stall records have `rd_repeat` = 0.
- R9: When a record is committed to a full buffer and no read happens in that cycle, the oldest entry is overwritten and `wrap_flag` goes high. `wrap_flag` clears while `cfg_enable` is low.
- R10: After an overwrite, the next retire or exception record to enter staging is full, even if its address is sequential.
- R11: Records leave in commit order. A read in the same cycle as a write loses nothing and does not set `wrap_flag`.
- R12: While `cfg_enable` is low no event is kept. A stall run still staged when capture is switched off is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Capture on |
| cfg_type_mask | input | 3 | Kept kinds: bit0 retire, bit1 stall, bit2 exception |
| cfg_pc_lo | input | AW | Lower address bound, inclusive |
| cfg_pc_hi | input | AW | Upper address bound, inclusive |
| rt_valid | input | 1 | Completion stage reports an event this cycle |
| rt_kind | input | 2 | Event kind (0 retire, 1 stall, 2 exception) |
| rt_pc | input | AW | Instruction address |
| rt_daddr | input | AW | Virtual data address |
| rt_wdata | input | DW | Register write-back value |
| rd_ready | input | 1 | Host takes the shown record |
| rd_valid | output | 1 | A record is shown |
| rd_kind | output | 2 | Record kind |
| rd_full | output | 1 | Record carries a full address |
| rd_repeat | output | 8 | Stall run length |
| rd_pc | output | AW | Instruction address, or zero |
| rd_daddr | output | AW | Data address |
| rd_wdata | output | DW | Write-back value |
| wrap_flag | output | 1 | Older history was overwritten |

## Verification
The bench builds the block with a buffer depth of 4, 16-bit addresses and data, and a 4-byte instruction size. With a depth of 4, an overwrite is reached after only five commits without a read, so the wrap flag and the forced full address after a wrap can be checked on a short sequence. A 300-cycle stall run drives the repeat count past its 255 limit. Continuous reading during back-to-back writes keeps the four-entry buffer near empty, which checks that a read and a write in the same cycle lose nothing.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        K_RETIRE = 2'd0,
        K_STALL  = 2'd1,
        K_EXC    = 2'd2,
        K_NONE   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_MERGE = 2'd2
    } stage_e;

    localparam int unsigned REP_W = 8;

    function automatic logic [REP_W-1:0] sat_inc(input logic [REP_W-1:0] v);
        return (&v) ? v : v + REP_W'(1);
    endfunction

endpackage

// File: rtl/trc_filter.sv
module trc_filter
    import trc_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          en,
    input  logic [2:0]    type_mask,
    input  logic [AW-1:0] pc_lo,
    input  logic [AW-1:0] pc_hi,
    input  logic          ev_valid,
    input  kind_e         ev_kind,
    input  logic [AW-1:0] ev_pc,
    output logic          keep
);
    logic type_ok;
    logic range_ok;

    always_comb begin
        unique case (ev_kind)
            K_RETIRE: type_ok = type_mask[0];
            K_STALL:  type_ok = type_mask[1];
            K_EXC:    type_ok = type_mask[2];
            default:  type_ok = 1'b0;
        endcase
        range_ok = (ev_pc >= pc_lo) && (ev_pc <= pc_hi);
        keep     = en && ev_valid && type_ok && range_ok;
    end

endmodule

// File: rtl/trc_stage.sv
module trc_stage
    import trc_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned DW         = 32,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ev_valid,
    input  logic             keep,
    input  kind_e            ev_kind,
    input  logic [AW-1:0]    ev_pc,
    input  logic [AW-1:0]    ev_daddr,
    input  logic [DW-1:0]    ev_wdata,
    input  logic             overwrite,
    output logic             commit,
    output kind_e            s_kind,
    output logic             s_full,
    output logic [REP_W-1:0] s_rep,
    output logic [AW-1:0]    s_pc,
    output logic [AW-1:0]    s_daddr,
    output logic [DW-1:0]    s_wdata
);
    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    stage_e        state, state_nx;
    logic          stall_cont;
    logic          load;
    logic          force_full;
    logic [AW-1:0] last_pc;
    logic          new_full;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions and commit strobe
    always_comb begin
        stall_cont = 1'b0;
        commit     = 1'b0;
        unique case (state)
            ST_IDLE:  begin
                stall_cont = 1'b0;
                commit     = 1'b0;
            end
            ST_HOLD:  begin
                stall_cont = 1'b0;
                commit     = 1'b1;
            end
            ST_MERGE: begin
                stall_cont = keep && (ev_kind == K_STALL);
                commit     = !stall_cont && (ev_valid || !en);
            end
            default:  begin
                stall_cont = 1'b0;
                commit     = 1'b0;
            end
        endcase
        load = keep && !stall_cont;
        if (load)            state_nx = (ev_kind == K_STALL) ? ST_MERGE : ST_HOLD; // T_LOAD_STALL / T_LOAD_REC
        else if (stall_cont) state_nx = ST_MERGE;                                   // T_MERGE
        else if (commit)     state_nx = ST_IDLE;                                    // T_FLUSH
        else                 state_nx = state;                                      // T_STAY
        new_full = (ev_kind == K_EXC) ||
                   ((ev_kind == K_RETIRE) && (force_full || (ev_pc != last_pc + STEP)));
    end

    // staged record, sequence tracking and forced full address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_kind     <= K_RETIRE;
            s_full     <= 1'b0;
            s_rep      <= '0;
            s_pc       <= '0;
            s_daddr    <= '0;
            s_wdata    <= '0;
            last_pc    <= '0;
            force_full <= 1'b1;
        end else begin
            if (load) begin
                s_kind <= ev_kind;
                if (ev_kind == K_STALL) begin
                    s_full  <= 1'b0;
                    s_rep   <= REP_W'(1);
                    s_pc    <= '0;
                    s_daddr <= '0;
                    s_wdata <= '0;
                end else begin
                    s_full  <= new_full;
                    s_rep   <= '0;
                    s_pc    <= new_full ? ev_pc : '0;
                    s_daddr <= ev_daddr;
                    s_wdata <= ev_wdata;
                    last_pc <= ev_pc;
                end
            end else if (stall_cont) begin
                s_rep <= sat_inc(s_rep);
            end
            if (!en || overwrite)                 force_full <= 1'b1;
            else if (load && ev_kind != K_STALL)  force_full <= 1'b0;
        end
    end

    p_exc_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ev_kind == K_EXC) |=> (s_full && s_kind == K_EXC && s_pc == $past(ev_pc)));

    p_merge_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cont && !(&s_rep)) |=> (s_rep == $past(s_rep) + REP_W'(1)));

    p_merge_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cont && (&s_rep)) |=> (&s_rep));

    p_hold_drains_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> commit);

endmodule

// File: rtl/trc_ring.sv
module trc_ring #(
    parameter int unsigned W     = 64,
    parameter int unsigned DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         rd_ready,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         wrap,
    output logic         overwrite
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          is_full;
    logic          pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        is_full   = (count == CW'(DEPTH));
        rd_valid  = (count != '0);
        rd_data   = mem[rd_ptr];
        pop       = rd_valid && rd_ready;
        overwrite = wr && is_full && !pop;
    end

    always_ff @(posedge clk) begin
        if (wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            wrap   <= 1'b0;
        end else begin
            if (wr)               wr_ptr <= bump(wr_ptr);
            if (pop || overwrite) rd_ptr <= bump(rd_ptr);
            if (wr && !pop && !is_full) count <= count + CW'(1);
            else if (pop && !wr)        count <= count - CW'(1);
            if (overwrite)  wrap <= 1'b1;
            else if (!en)   wrap <= 1'b0;
        end
    end

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_overwrite_sets_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overwrite |=> (wrap && count == $past(count)));

    p_pop_drops_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !wr) |=> (count == $past(count) - CW'(1)));

    p_rw_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && wr) |=> (count == $past(count) && wrap == $past(wrap)));

endmodule

// File: rtl/trace_capture.sv
module trace_capture
    import trc_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned DW         = 32,
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic [2:0]    cfg_type_mask,
    input  logic [AW-1:0] cfg_pc_lo,
    input  logic [AW-1:0] cfg_pc_hi,
    input  logic          rt_valid,
    input  logic [1:0]    rt_kind,
    input  logic [AW-1:0] rt_pc,
    input  logic [AW-1:0] rt_daddr,
    input  logic [DW-1:0] rt_wdata,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [1:0]    rd_kind,
    output logic          rd_full,
    output logic [7:0]    rd_repeat,
    output logic [AW-1:0] rd_pc,
    output logic [AW-1:0] rd_daddr,
    output logic [DW-1:0] rd_wdata,
    output logic          wrap_flag
);
    localparam int unsigned REC_W = 2 + 1 + REP_W + AW + AW + DW;

    kind_e             ev_kind;
    logic              keep;
    logic              commit;
    logic              overwrite;
    kind_e             s_kind;
    logic              s_full;
    logic [REP_W-1:0]  s_rep;
    logic [AW-1:0]     s_pc, s_daddr;
    logic [DW-1:0]     s_wdata;
    logic [REC_W-1:0]  wr_rec, rd_rec;

    assign ev_kind = kind_e'(rt_kind);

    trc_filter #(.AW(AW)) u_filter (
        .en        (cfg_enable),
        .type_mask (cfg_type_mask),
        .pc_lo     (cfg_pc_lo),
        .pc_hi     (cfg_pc_hi),
        .ev_valid  (rt_valid),
        .ev_kind   (ev_kind),
        .ev_pc     (rt_pc),
        .keep      (keep)
    );

    trc_stage #(.AW(AW), .DW(DW), .INSN_BYTES(INSN_BYTES)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_enable),
        .ev_valid  (rt_valid),
        .keep      (keep),
        .ev_kind   (ev_kind),
        .ev_pc     (rt_pc),
        .ev_daddr  (rt_daddr),
        .ev_wdata  (rt_wdata),
        .overwrite (overwrite),
        .commit    (commit),
        .s_kind    (s_kind),
        .s_full    (s_full),
        .s_rep     (s_rep),
        .s_pc      (s_pc),
        .s_daddr   (s_daddr),
        .s_wdata   (s_wdata)
    );

    assign wr_rec = {s_kind, s_full, s_rep, s_pc, s_daddr, s_wdata};

    trc_ring #(.W(REC_W), .DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_enable),
        .wr        (commit),
        .wr_data   (wr_rec),
        .rd_ready  (rd_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_rec),
        .wrap      (wrap_flag),
        .overwrite (overwrite)
    );

    assign {rd_kind, rd_full, rd_repeat, rd_pc, rd_daddr, rd_wdata} = rd_rec;

    p_idle_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> !keep);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rd_valid && !wrap_flag));

endmodule

// File: tb/trace_capture_tb.sv
module trace_capture_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_enable;
    logic [2:0]    cfg_type_mask;
    logic [AW-1:0] cfg_pc_lo, cfg_pc_hi;
    logic          rt_valid;
    logic [1:0]    rt_kind;
    logic [AW-1:0] rt_pc, rt_daddr;
    logic [DW-1:0] rt_wdata;
    logic          rd_ready;
    logic          rd_valid;
    logic [1:0]    rd_kind;
    logic          rd_full;
    logic [7:0]    rd_repeat;
    logic [AW-1:0] rd_pc, rd_daddr;
    logic [DW-1:0] rd_wdata;
    logic          wrap_flag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    trace_capture #(.AW(AW), .DW(DW), .DEPTH(4), .INSN_BYTES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_type_mask(cfg_type_mask),
        .cfg_pc_lo(cfg_pc_lo), .cfg_pc_hi(cfg_pc_hi), .rt_valid(rt_valid), .rt_kind(rt_kind),
        .rt_pc(rt_pc), .rt_daddr(rt_daddr), .rt_wdata(rt_wdata), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_kind(rd_kind), .rd_full(rd_full), .rd_repeat(rd_repeat),
        .rd_pc(rd_pc), .rd_daddr(rd_daddr), .rd_wdata(rd_wdata), .wrap_flag(wrap_flag)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] k, input logic [15:0] pc,
                        input logic [15:0] da, input logic [15:0] wd);
        rt_valid = v; rt_kind = k; rt_pc = pc; rt_daddr = da; rt_wdata = wd;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 16'h0, 16'h0, 16'h0);
    endtask

    task automatic pop_expect(input string tag, input logic [1:0] k, input logic f, input logic [7:0] rep,
                              input logic [15:0] pc, input logic [15:0] da, input logic [15:0] wd);
        logic [63:0] act, exp;
        act = {rd_valid, 3'b0, 2'b0, rd_kind, 3'b0, rd_full, rd_repeat, rd_pc, rd_daddr, rd_wdata};
        exp = {1'b1, 3'b0, 2'b0, k, 3'b0, f, rep, pc, da, wd};
        chk(act == exp, tag, act, exp);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        chk(rd_valid == 1'b0, tag, 64'(rd_valid), 64'h0);
    endtask

    task automatic t_reset;
        chk(rd_valid == 1'b0 && wrap_flag == 1'b0, "R1 reset state", {rd_valid, wrap_flag}, 64'h0);
    endtask

    task automatic t_compress;
        cfg_enable = 1'b1;
        step(1, 2'd0, 16'h0100, 16'h0010, 16'h00AA);
        step(1, 2'd0, 16'h0104, 16'h0014, 16'h00BB);
        step(1, 2'd0, 16'h0200, 16'h0020, 16'h00CC);
        step(1, 2'd2, 16'h0204, 16'h0024, 16'h00DD);
        idle(3);
        pop_expect("R5 R2 first record full", 2'd0, 1, 0, 16'h0100, 16'h0010, 16'h00AA);
        pop_expect("R3 sequential no address", 2'd0, 0, 0, 16'h0000, 16'h0014, 16'h00BB);
        pop_expect("R4 jump full address", 2'd0, 1, 0, 16'h0200, 16'h0020, 16'h00CC);
        pop_expect("R4 exception full address", 2'd2, 1, 0, 16'h0204, 16'h0024, 16'h00DD);
        expect_empty("R11 drained");
    endtask

    task automatic t_mask;
        cfg_type_mask = 3'b001;
        step(1, 2'd1, 16'h0300, 16'h0, 16'h0);
        step(1, 2'd2, 16'h0300, 16'h0, 16'h0);
        step(1, 2'd0, 16'h0304, 16'h0, 16'h0011);
        idle(3);
        pop_expect("R6 retire only kept", 2'd0, 1, 0, 16'h0304, 16'h0, 16'h0011);
        expect_empty("R6 stall and exception dropped");
        cfg_type_mask = 3'b100;
        step(1, 2'd0, 16'h0308, 16'h0, 16'h0);
        step(1, 2'd2, 16'h040C, 16'h0004, 16'h0022);
        idle(3);
        pop_expect("R6 exception only kept", 2'd2, 1, 0, 16'h040C, 16'h0004, 16'h0022);
        expect_empty("R6 retire dropped");
        cfg_type_mask = 3'b111;
    endtask

    task automatic t_range;
        cfg_pc_lo = 16'h0500; cfg_pc_hi = 16'h050C;
        step(1, 2'd0, 16'h04FC, 16'h0, 16'h0);
        step(1, 2'd0, 16'h0500, 16'h0, 16'h0031);
        step(1, 2'd0, 16'h0504, 16'h0, 16'h0032);
        step(1, 2'd0, 16'h050C, 16'h0, 16'h0033);
        step(1, 2'd0, 16'h0510, 16'h0, 16'h0);
        idle(3);
        pop_expect("R7 lower bound inclusive", 2'd0, 1, 0, 16'h0500, 16'h0, 16'h0031);
        pop_expect("R7 inside range sequential", 2'd0, 0, 0, 16'h0000, 16'h0, 16'h0032);
        pop_expect("R7 upper bound inclusive", 2'd0, 1, 0, 16'h050C, 16'h0, 16'h0033);
        expect_empty("R7 out of range dropped");
        cfg_pc_lo = 16'h0000; cfg_pc_hi = 16'hFFFF;
    endtask

    task automatic t_stall;
        for (int i = 0; i < 3; i++) step(1, 2'd1, 16'h0600, 16'h0, 16'h0);
        step(1, 2'd0, 16'h0510, 16'h0, 16'h0041);
        idle(3);
        pop_expect("R8 stall run of three", 2'd1, 0, 8'd3, 16'h0, 16'h0, 16'h0);
        pop_expect("R8 run ended by retire", 2'd0, 0, 0, 16'h0, 16'h0, 16'h0041);
        for (int i = 0; i < 300; i++) step(1, 2'd1, 16'h0600, 16'h0, 16'h0);
        step(1, 2'd0, 16'h0514, 16'h0, 16'h0042);
        idle(3);
        pop_expect("R8 repeat saturates at 255", 2'd1, 0, 8'd255, 16'h0, 16'h0, 16'h0);
        pop_expect("R8 retire after long run", 2'd0, 0, 0, 16'h0, 16'h0, 16'h0042);
        expect_empty("R8 drained");
    endtask

    task automatic t_concurrent;
        logic [15:0] got [16];
        logic        fulls [16];
        int          n = 0;
        rd_ready = 1'b1;
        for (int c = 0; c < 16; c++) begin
            if (rd_valid && n < 16) begin
                got[n] = rd_wdata; fulls[n] = rd_full; n++;
            end
            if (c < 10) step(1, 2'd0, 16'(16'h0800 + 4 * c), 16'h0, 16'(c));
            else        idle(1);
        end
        rd_ready = 1'b0;
        chk(n == 10, "R11 no record lost", 64'(n), 64'd10);
        for (int i = 0; i < 10 && i < n; i++) begin
            chk(got[i] == 16'(i) && fulls[i] == (i == 0), "R11 commit order",
                {fulls[i], got[i]}, {(i == 0), 16'(i)});
        end
        chk(wrap_flag == 1'b0, "R11 no wrap on read-write", 64'(wrap_flag), 64'h0);
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 7; i++) step(1, 2'd0, 16'(16'h0900 + 4 * i), 16'h0, 16'(16'h50 + i));
        idle(3);
        chk(wrap_flag == 1'b1, "R9 wrap after overwrite", 64'(wrap_flag), 64'h1);
        pop_expect("R9 oldest survivor", 2'd0, 0, 0, 16'h0, 16'h0, 16'h0053);
        pop_expect("R9 survivor 2", 2'd0, 0, 0, 16'h0, 16'h0, 16'h0054);
        pop_expect("R9 survivor 3", 2'd0, 0, 0, 16'h0, 16'h0, 16'h0055);
        pop_expect("R10 full after overwrite", 2'd0, 1, 0, 16'h0918, 16'h0, 16'h0056);
        expect_empty("R9 four entries kept");
        step(1, 2'd0, 16'h091C, 16'h0, 16'h0057);
        idle(3);
        pop_expect("R10 still forced after wrap", 2'd0, 1, 0, 16'h091C, 16'h0, 16'h0057);
        cfg_enable = 1'b0;
        idle(1);
        chk(wrap_flag == 1'b0, "R9 wrap cleared by disable", 64'(wrap_flag), 64'h0);
    endtask

    task automatic t_disabled;
        step(1, 2'd0, 16'h0A00, 16'h0, 16'h0);
        step(1, 2'd2, 16'h0A04, 16'h0, 16'h0);
        idle(3);
        expect_empty("R12 nothing kept while off");
        cfg_enable = 1'b1;
        step(1, 2'd0, 16'h0920, 16'h0, 16'h0061);
        idle(3);
        pop_expect("R5 sequential forced full on enable", 2'd0, 1, 0, 16'h0920, 16'h0, 16'h0061);
        step(1, 2'd1, 16'h0B00, 16'h0, 16'h0);
        step(1, 2'd1, 16'h0B00, 16'h0, 16'h0);
        cfg_enable = 1'b0;
        idle(3);
        pop_expect("R12 staged stall run flushed", 2'd1, 0, 8'd2, 16'h0, 16'h0, 16'h0);
        expect_empty("R12 drained");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_enable = 1'b0; cfg_type_mask = 3'b111;
        cfg_pc_lo = 16'h0000; cfg_pc_hi = 16'hFFFF;
        rt_valid = 1'b0; rt_kind = 2'd0; rt_pc = '0; rt_daddr = '0; rt_wdata = '0;
        rd_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_compress;
        t_mask;
        t_range;
        t_stall;
        t_concurrent;
        t_wrap;
        t_disabled;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule